// File: doc/BRIEF.md
# I2S Master Stereo Transmitter

This block drives a stereo audio DAC over a standard I2S link. It generates the bit clock and the word-select clock itself and shifts 32-bit sample words out on a single data line. Each word goes out MSB first, and its first bit starts one bit period after the word-select edge. A clock-enable `tick` from a parent divider sets the link rate. With no master clock configured, every tick toggles the bit clock, so one data bit takes two ticks: one for the low phase and one for the high phase.

Sample words come in through a valid/ready handshake. The block requests one word at the start of every slot, left channel first and then right. Each word is sent exactly as it was given, so a 24-bit sample placed in bits 31..8 comes out as a 24-bit sample followed by eight don't-care bits. If no word is offered when one is needed, the slot carries zeros and an underflow flag pulses.

When `MCLK_RATIO` is set to 256 or 384, the block also produces a master clock from the same tick. In that case `tick` runs at twice the master-clock rate, and each bit-clock phase lasts `MCLK_RATIO/64` ticks, so the master clock divides the frame exactly.

The control state machine has three states:
- `ST_IDLE`: the outputs are held low.
- `ST_LEFT`: word-select is low.
- `ST_RIGHT`: word-select is high.

Its transitions are:
- start, `ST_IDLE`→`ST_LEFT`: `enable` is high on a tick.
- slot change, `ST_LEFT`→`ST_RIGHT` and `ST_RIGHT`→`ST_LEFT`: the 32nd bit period of a slot ends.
- stop, any running state→`ST_IDLE`: `enable` is low.

Top module: `i2s_tx_master`

## Requirements
- R1: While running, the bit clock changes exactly when the bit-clock phase count completes: once per `tick` when `MCLK_RATIO`=0, and once every `MCLK_RATIO/64` ticks otherwise. A channel slot lasts 32 bit-clock periods, so a frame lasts 64.
- R2: Word-select is low (0) during the left slot and high (1) during the right slot. The first slot after enabling is the left slot, and the received words alternate left, right, left, and so on.
- R3: Within a slot, bit 31 of the word is sent in the second bit period, and the lower bits follow in descending order. Bit 0 is sent in the first bit period of the following slot.
- R4: `sdo` and `ws` change only on the clock cycle in which the bit clock falls, except when the block stops.
- R5: `s_ready` is high for one cycle at the start of each slot, on the tick that begins the slot. A word accepted with `s_valid` high is sent unchanged, all 32 bits.
- R6: If `s_valid` is low while `s_ready` is high, the slot sends 32 zero bits, and `underflow` is high for exactly the following clock cycle. Otherwise `underflow` stays low.
- R7: After reset, and on the cycle after `enable` is sampled low, `bck`, `ws` and `sdo` are low and stay low until `enable` is high on a tick. Stopping discards any partly sent word.
- R8: With `MCLK_RATIO` at 256 or 384, `mclk` toggles on every tick while running and rises exactly `MCLK_RATIO` times per word-select period. With `MCLK_RATIO`=0, `mclk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable that sets the link rate |
| enable | input | 1 | Run request; low stops the link immediately |
| s_data | input | 32 | Sample word, MSB first on the wire |
| s_valid | input | 1 | `s_data` holds a word |
| s_ready | output | 1 | Word taken this cycle (start of a slot) |
| bck | output | 1 | Bit clock |
| ws | output | 1 | Word select, 0 = left, 1 = right |
| sdo | output | 1 | Serial data to the DAC |
| mclk | output | 1 | Frame-locked master clock, or 0 |
| underflow | output | 1 | One-cycle pulse: a slot had no word |

## Verification
The bench decodes the line the way a DAC does, sampling on each rising bit-clock edge. Using all-ones, single-end-bit and alternating words, it catches a design that drops the one-bit delay, swaps the channels, or puts bit 0 in the wrong slot; each of these gives rotated or misaligned words. Irregular tick patterns expose a bit clock that advances without a tick or misses one, and a slot that is not 32 bits long trips the slot-length check. Stopping mid-frame and sustained starvation show whether the lines fall to zero and whether the underflow pulse lines up with the missed word. A second instance with a 384× master clock checks that the master clock and bit clock counts per frame are exact.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } tx_state_t;
endpackage

// File: rtl/i2s_tx_pacer.sv
// Divides the tick into bit-clock phases and derives the master clock.
module i2s_tx_pacer #(
    parameter int HALF_TICKS = 1,
    parameter bit MCLK_ON    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic step,
    output logic mclk
);
    localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!run)
            div_q <= '0;
        else if (tick)
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    assign step = run && tick && (div_q == LAST);

    generate
        if (MCLK_ON) begin : g_mclk
            logic mclk_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mclk_q <= 1'b0;
                else if (!run)
                    mclk_q <= 1'b0;
                else if (tick)
                    mclk_q <= ~mclk_q;
            end
            assign mclk = mclk_q;
        end else begin : g_no_mclk
            assign mclk = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/i2s_tx_shifter.sv
// Holds the unsent bits of the current word and drives the data line.
module i2s_tx_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    input  logic         din_ok,
    output logic         sdo,
    output logic         underflow
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q      <= '0;
            sdo       <= 1'b0;
            underflow <= 1'b0;
        end else begin
            underflow <= load && !din_ok && !clear;
            if (clear) begin
                sr_q <= '0;
                sdo  <= 1'b0;
            end else if (load) begin
                sdo  <= sr_q[W-1];
                sr_q <= din_ok ? din : '0;
            end else if (shift) begin
                sdo  <= sr_q[W-1];
                sr_q <= {sr_q[W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master #(
    parameter int SLOT_W     = 32,
    parameter int MCLK_RATIO = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic [SLOT_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic              bck,
    output logic              ws,
    output logic              sdo,
    output logic              mclk,
    output logic              underflow
);
    import i2s_tx_pkg::*;

    localparam int HALF_TICKS = (MCLK_RATIO == 0) ? 1 : MCLK_RATIO / 64;
    localparam bit MCLK_ON    = (MCLK_RATIO != 0);
    localparam int CNT_W      = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SLOT_W - 1);

    tx_state_t      state_q, state_d;
    logic           bck_q;
    logic [CNT_W-1:0] bit_q;
    logic           running, step, start, bit_end, slot_end, load, shift;

    assign running  = (state_q != ST_IDLE);
    assign start    = (state_q == ST_IDLE) && enable && tick;
    assign bit_end  = step && bck_q;
    assign slot_end = bit_end && (bit_q == LAST_BIT);
    assign load     = start || (enable && slot_end);
    assign shift    = enable && bit_end && !slot_end;

    i2s_tx_pacer #(.HALF_TICKS(HALF_TICKS), .MCLK_ON(MCLK_ON)) u_pacer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(running),
        .step(step), .mclk(mclk)
    );

    i2s_tx_shifter #(.W(SLOT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(!enable), .load(load),
        .shift(shift), .din(s_data), .din_ok(s_valid),
        .sdo(sdo), .underflow(underflow)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEFT;
            ST_LEFT:  if (!enable) state_d = ST_IDLE;
                      else if (slot_end) state_d = ST_RIGHT;
            ST_RIGHT: if (!enable) state_d = ST_IDLE;
                      else if (slot_end) state_d = ST_LEFT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit clock and bit position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bck_q <= 1'b0;
            bit_q <= '0;
        end else if (!enable || !running) begin
            bck_q <= 1'b0;
            bit_q <= '0;
        end else if (step) begin
            if (bck_q) begin
                bck_q <= 1'b0;
                bit_q <= slot_end ? '0 : bit_q + 1'b1;
            end else begin
                bck_q <= 1'b1;
            end
        end
    end

    assign bck     = bck_q;
    assign ws      = (state_q == ST_RIGHT);
    assign s_ready = load;
endmodule

// File: rtl/i2s_tx_master_chk.sv
module i2s_tx_master_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic enable,
    input logic s_valid,
    input logic s_ready,
    input logic bck,
    input logic ws,
    input logic sdo,
    input logic underflow
);
    a_r1_bck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bck) && $past(enable)) |-> $past(tick));

    a_r4_ws_on_bck_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ws) && $past(enable)) |-> $fell(bck));

    a_r4_sdo_on_bck_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) && $past(enable)) |-> $fell(bck));

    a_r5_ready_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (tick && enable));

    a_r6_underflow_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> $past(s_ready && !s_valid));

    a_r6_miss_flags_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> underflow);

    a_r7_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable) |-> (!bck && !ws && !sdo && !underflow));
endmodule

bind i2s_tx_master i2s_tx_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .s_valid(s_valid), .s_ready(s_ready), .bck(bck), .ws(ws),
    .sdo(sdo), .underflow(underflow)
);

// File: tb/i2s_tx_master_tb.sv
module i2s_tx_master_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, en = 1'b0, s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic s_ready, bck, ws, sdo, mclk, underflow;

    logic tick_mc = 1'b0, en_mc = 1'b0;
    logic rdy_mc, bck_mc, ws_mc, sdo_mc, mclk_mc, uf_mc;

    always #4 clk = ~clk;

    i2s_tx_master u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .bck(bck), .ws(ws), .sdo(sdo), .mclk(mclk), .underflow(underflow)
    );

    i2s_tx_master #(.MCLK_RATIO(384)) u_dut_mc (
        .clk(clk), .rst_n(rst_n), .tick(tick_mc), .enable(en_mc),
        .s_data(32'hC0FFEE00), .s_valid(1'b1), .s_ready(rdy_mc),
        .bck(bck_mc), .ws(ws_mc), .sdo(sdo_mc), .mclk(mclk_mc), .underflow(uf_mc)
    );

    int checks = 0, errors = 0;
    int tick_mode = 0, val_mode = 0;
    logic en_next = 1'b0, rst_next = 1'b0;
    logic took = 1'b0, started = 1'b0;
    logic run_l = 1'b0, tick_l = 1'b0, en_l = 1'b0, pend_uf = 1'b0;
    logic [31:0] expq[$];
    int dir_idx = 0;
    logic [31:0] dir_words [6] = '{32'h80000001, 32'hFFFFFFFF, 32'h00000000,
                                  32'hA5A5A5A5, 32'h12345600, 32'h7FFFFFFF};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit pick_valid(input int mode);
        if (mode == 1) return 1'b0;
        return ($urandom % 10) < 7;
    endfunction

    task automatic cycle();
        @(negedge clk);
        rst_n = rst_next;
        en    = en_next;
        tick  = (tick_mode == 0) ? 1'b1 : 1'($urandom % 2);
        tick_mc = rst_next;
        en_mc   = rst_next;
        if (!s_valid || took) begin
            if (val_mode == 0 && dir_idx < 6) begin
                s_valid = 1'b1;
                s_data  = dir_words[dir_idx];
                dir_idx++;
            end else begin
                s_valid = pick_valid(val_mode);
                s_data  = $urandom;
            end
        end
        #1;
        run_l   = started;
        tick_l  = tick;
        en_l    = en;
        took    = s_ready && s_valid;
        pend_uf = s_ready && !s_valid;
        if (s_ready) begin
            expq.push_back(s_valid ? s_data : 32'h0);
            started = 1'b1;
        end
        if (!en) started = 1'b0;
    endtask

    // receiver and monitors
    logic bck_p = 1'b0, ws_rx_p = 1'b0;
    int rx_cnt = -1, rx_words = 0;
    logic rx_chan = 1'b0;
    logic [31:0] acc = '0;
    logic bck_mc_p = 1'b0, ws_mc_p = 1'b0, mclk_mc_p = 1'b0;
    int mc_b = 0, mc_m = 0;
    bit mc_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!en_l) begin
                check(!bck && !ws && !sdo, "R7 idle lines", {29'd0, bck, ws, sdo}, 32'd0);
                rx_cnt = -1; rx_words = 0; ws_rx_p = 1'b0; expq.delete();
            end else if (run_l) begin
                check((bck != bck_p) == tick_l, "R1 bck toggles per tick",
                      {31'd0, bck != bck_p}, {31'd0, tick_l});
            end
            check(underflow == pend_uf, "R6 underflow pulse", {31'd0, underflow}, {31'd0, pend_uf});
            check(mclk == 1'b0, "R8 mclk off", {31'd0, mclk}, 32'd0);

            if (bck && !bck_p) begin
                int cnt_r;
                cnt_r = rx_cnt + 1;
                if (rx_cnt < 0)
                    check(ws == 1'b0, "R2 first slot left", {31'd0, ws}, 32'd0);
                if (cnt_r >= 1 && cnt_r <= 32) acc = {acc[30:0], sdo};
                if (cnt_r == 32) begin
                    if (expq.size() == 0)
                        check(1'b0, "R5 word without request", acc, 32'hx);
                    else begin
                        logic [31:0] e;
                        e = expq.pop_front();
                        check(acc == e, "R3/R5 word bits", acc, e);
                    end
                    check(rx_chan == 1'(rx_words % 2), "R2 channel order",
                          {31'd0, rx_chan}, rx_words % 2);
                    rx_words++;
                end
                if (rx_cnt < 0) begin
                    rx_chan = ws; rx_cnt = 0;
                end else if (ws != ws_rx_p) begin
                    check(cnt_r == 32, "R1 slot length", cnt_r, 32);
                    rx_chan = ws; rx_cnt = 0;
                end else begin
                    rx_cnt = cnt_r;
                end
                ws_rx_p = ws;
            end
            bck_p = bck;

            if (bck_mc && !bck_mc_p) mc_b++;
            if (mclk_mc && !mclk_mc_p) mc_m++;
            if (ws_mc && !ws_mc_p) begin
                if (mc_seen) begin
                    check(mc_m == 384, "R8 mclk per frame", mc_m, 384);
                    check(mc_b == 64, "R1 bck per frame (mclk mode)", mc_b, 64);
                end
                mc_seen = 1'b1; mc_m = 0; mc_b = 0;
            end
            bck_mc_p = bck_mc; ws_mc_p = ws_mc; mclk_mc_p = mclk_mc;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        tick_mode = 1; val_mode = 2;
        repeat (5) cycle();
        rst_next = 1'b1;
        // R7: idle with ticks running and enable low
        repeat (20) cycle();
        // directed corner words, continuous ticks (R3, R5)
        tick_mode = 0; val_mode = 0; en_next = 1'b1;
        repeat (600) cycle();
        // stop mid-frame (R7)
        en_next = 1'b0;
        repeat (4) cycle();
        // starvation: every slot underflows (R6)
        val_mode = 1; en_next = 1'b1;
        repeat (300) cycle();
        en_next = 1'b0;
        repeat (3) cycle();
        // random ticks and valid gaps
        tick_mode = 1; val_mode = 2; en_next = 1'b1;
        repeat (3000) cycle();
        en_next = 1'b0;
        repeat (5) cycle();
        tick_mode = 0; en_next = 1'b1;
        repeat (1500) cycle();
        en_next = 1'b0;
        repeat (5) cycle();
        check(rx_words == 0 && !bck, "R7 stopped at end", {31'd0, bck}, 32'd0);
        finish_run();
    end
endmodule